// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block derives a panel pixel clock from a reference clock. The division ratio comes from a control word. A divisor value is held as the divisor minus two, split into a low field and a high field that sit at separate positions in the word. One bypass bit passes the reference clock straight through, which gives a divide-by-one. A change to the word takes effect only when the output period in progress has finished, so a reprogramming never produces a shortened pulse.

A combinational helper sits beside the divider and shares the same word layout. It takes a reference rate and a target rate. It returns the control word whose divisor gives the closest rate, where that rate is the reference rate divided by the divisor and rounded up. Software or a sequencer can write that word into the control input.

Top module: `pclk_divider`

## Requirements
- R1: While `rst` is high, `pix_clk` stays low from the first reference edge on.
- R2: When bypass (bit 5) is clear, the divisor is d = F + 2. F is the 10-bit value formed with bits [4:0] as its low five bits and bits [15:11] as its high five bits. Each `pix_clk` period lasts d reference cycles.
- R3: When bit 5 is set, `pix_clk` has the reference period and is high during the reference high phase, whatever the field bits hold.
- R4: In divided mode `pix_clk` is high for floor(d/2) reference cycles and then low for the rest of the period. An odd divisor therefore gives a high time one cycle shorter than the low time.
- R5: A control word change made partway through a period does not alter that period. The new setting applies from the next period boundary.
- R6: Every high pulse and every low pulse of `pix_clk` lasts at least half a reference cycle. This holds across changes of divisor and across entry to and exit from bypass.
- R7: The helper returns the word for the divisor d in 1..1025 that minimises |T − ceil(R/d)|, taking the smaller d on a tie. For d = 1 it sets only bit 5. Otherwise it places d − 2 in the split field with bit 5 clear. All other bits are zero.
- R8: When the target rate exceeds the reference rate, the helper returns the bypass word. When R/T is above 1025, or T is zero, it returns the word for 1025, with both fields all ones.
- R9: The largest field value gives a period of 1025 reference cycles with 512 cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 32 | Divisor fields and bypass bit |
| pix_clk | output | 1 | Divided or bypassed pixel clock |
| pick_ref | input | 24 | Helper: reference rate |
| pick_tgt | input | 24 | Helper: target rate |
| pick_word | output | 32 | Helper: closest control word encoding |

## Verification
A new control word becomes visible at the first period boundary after it is applied. It can take up to one full old period plus one reference cycle to show. The bench therefore lets three `pix_clk` rising edges pass after each change before its scoreboard starts comparing periods and high times, which it measures in half reference cycles. The boundary case instead times the period that is in progress when the word changes, and then the period right after it. The helper is purely combinational, so its word is sampled one nanosecond after its inputs are driven.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int unsigned CTL_W_DEF   = 32;
  localparam int unsigned LO_POS_DEF  = 0;
  localparam int unsigned LO_W_DEF    = 5;
  localparam int unsigned BYP_POS_DEF = 5;
  localparam int unsigned HI_POS_DEF  = 11;
  localparam int unsigned HI_W_DEF    = 5;
  localparam int unsigned RATE_W_DEF  = 24;

  typedef enum logic {MODE_DIV = 1'b0, MODE_BYP = 1'b1} pclk_mode_e;
endpackage

// File: rtl/pclk_div_core.sv
module pclk_div_core #(
  parameter int unsigned LO_W  = 5,
  parameter int unsigned HI_W  = 5,
  localparam int unsigned FLD_W = LO_W + HI_W,
  localparam int unsigned DIV_W = FLD_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LO_W-1:0]  fld_lo,
  input  logic [HI_W-1:0]  fld_hi,
  input  logic             byp_req,
  output logic             bnd,
  output logic             byp_act,
  output logic             q_lvl,
  output logic [DIV_W-1:0] act_div
);
  import pclk_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] new_div;
  logic [DIV_W-1:0] cnt_inc;
  logic [DIV_W-1:0] half_len;
  pclk_mode_e       mode_q;

  assign new_div  = {1'b0, fld_hi, fld_lo} + DIV_W'(2);
  assign cnt_inc  = cnt + DIV_W'(1);
  assign half_len = act_div >> 1;
  assign byp_act  = (mode_q == MODE_BYP);
  assign bnd      = byp_act || (cnt == act_div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div <= DIV_W'(2);
      cnt     <= DIV_W'(1);
      mode_q  <= MODE_DIV;
      q_lvl   <= 1'b0;
    end else if (bnd) begin
      act_div <= new_div;
      cnt     <= '0;
      mode_q  <= byp_req ? MODE_BYP : MODE_DIV;
      q_lvl   <= !byp_req;
    end else begin
      cnt     <= cnt_inc;
      q_lvl   <= (cnt_inc < half_len);
    end
  end
endmodule

// File: rtl/pclk_out_gate.sv
module pclk_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic byp_act,
  input  logic q_lvl,
  output logic pix_clk
);
  logic en_n;

  always_ff @(negedge clk) begin
    if (rst) en_n <= 1'b0;
    else     en_n <= byp_act;
  end

  assign pix_clk = (clk & en_n) | q_lvl;
endmodule

// File: rtl/pclk_div_pick.sv
module pclk_div_pick #(
  parameter int unsigned CTL_W   = 32,
  parameter int unsigned LO_POS  = 0,
  parameter int unsigned LO_W    = 5,
  parameter int unsigned BYP_POS = 5,
  parameter int unsigned HI_POS  = 11,
  parameter int unsigned HI_W    = 5,
  parameter int unsigned RATE_W  = 24,
  localparam int unsigned FLD_W  = LO_W + HI_W,
  localparam int unsigned DIV_W  = FLD_W + 1,
  localparam int unsigned W1     = RATE_W + 1,
  localparam int unsigned MAX_DIV = (1 << FLD_W) + 1
) (
  input  logic [RATE_W-1:0] ref_rate,
  input  logic [RATE_W-1:0] tgt_rate,
  output logic [CTL_W-1:0]  word
);
  logic [W1-1:0]    r1, t1, quo, c1, f0, f1, e0, e1;
  logic [DIV_W-1:0] dsel;
  logic [DIV_W-1:0] fval;

  always_comb begin
    r1  = {1'b0, ref_rate};
    t1  = {1'b0, tgt_rate};
    quo = '0;
    c1  = '0;
    f0  = '0;
    f1  = '0;
    e0  = '0;
    e1  = '0;
    if (t1 != '0) quo = r1 / t1;
    if (t1 == '0 || quo >= W1'(MAX_DIV)) begin
      dsel = DIV_W'(MAX_DIV);
    end else if (quo == '0) begin
      dsel = DIV_W'(1);
    end else begin
      c1   = quo;
      f0   = (r1 + c1 - W1'(1)) / c1;
      f1   = (r1 + c1) / (c1 + W1'(1));
      e0   = f0 - t1;
      e1   = t1 - f1;
      dsel = (e0 <= e1) ? c1[DIV_W-1:0] : c1[DIV_W-1:0] + DIV_W'(1);
    end
  end

  assign fval = dsel - DIV_W'(2);

  always_comb begin
    word = '0;
    if (dsel == DIV_W'(1)) begin
      word[BYP_POS] = 1'b1;
    end else begin
      word[LO_POS +: LO_W] = fval[LO_W-1:0];
      word[HI_POS +: HI_W] = fval[FLD_W-1:LO_W];
    end
  end
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pclk_pkg::*;
#(
  parameter int unsigned CTL_W   = CTL_W_DEF,
  parameter int unsigned LO_POS  = LO_POS_DEF,
  parameter int unsigned LO_W    = LO_W_DEF,
  parameter int unsigned BYP_POS = BYP_POS_DEF,
  parameter int unsigned HI_POS  = HI_POS_DEF,
  parameter int unsigned HI_W    = HI_W_DEF,
  parameter int unsigned RATE_W  = RATE_W_DEF,
  localparam int unsigned DIV_W  = LO_W + HI_W + 1
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic [CTL_W-1:0]  ctl_word,
  output logic              pix_clk,
  input  logic [RATE_W-1:0] pick_ref,
  input  logic [RATE_W-1:0] pick_tgt,
  output logic [CTL_W-1:0]  pick_word
);
  logic             bnd;
  logic             byp_act;
  logic             q_lvl;
  logic [DIV_W-1:0] act_div;

  pclk_div_core #(.LO_W(LO_W), .HI_W(HI_W)) u_core (
    .clk     (clk_ref),
    .rst     (rst),
    .fld_lo  (ctl_word[LO_POS +: LO_W]),
    .fld_hi  (ctl_word[HI_POS +: HI_W]),
    .byp_req (ctl_word[BYP_POS]),
    .bnd     (bnd),
    .byp_act (byp_act),
    .q_lvl   (q_lvl),
    .act_div (act_div)
  );

  pclk_out_gate u_gate (
    .clk     (clk_ref),
    .rst     (rst),
    .byp_act (byp_act),
    .q_lvl   (q_lvl),
    .pix_clk (pix_clk)
  );

  pclk_div_pick #(
    .CTL_W(CTL_W), .LO_POS(LO_POS), .LO_W(LO_W), .BYP_POS(BYP_POS),
    .HI_POS(HI_POS), .HI_W(HI_W), .RATE_W(RATE_W)
  ) u_pick (
    .ref_rate (pick_ref),
    .tgt_rate (pick_tgt),
    .word     (pick_word)
  );
endmodule

// File: rtl/pclk_divider_chk.sv
module pclk_divider_chk #(
  parameter int unsigned DIV_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      ctl_word,
  input logic             bnd,
  input logic             byp_act,
  input logic             q_lvl,
  input logic [DIV_W-1:0] act_div
);
  logic [DIV_W-1:0] run_cnt;
  logic [DIV_W-1:0] fld_div;

  assign fld_div = {1'b0, ctl_word[15:11], ctl_word[4:0]} + DIV_W'(2);

  always_ff @(posedge clk) begin
    if (rst)        run_cnt <= '0;
    else if (q_lvl) run_cnt <= run_cnt + DIV_W'(1);
    else            run_cnt <= '0;
  end

  // R2: a boundary in divided mode loads field value plus two
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (bnd && !ctl_word[5]) |=> (act_div == $past(fld_div)));

  // R3: bypass keeps the divided level low
  a_r3_byp_quiet: assert property (@(posedge clk) disable iff (rst)
    byp_act |-> !q_lvl);

  // R4: high run equals half the divisor, rounded down
  a_r4_high_len: assert property (@(posedge clk) disable iff (rst)
    $fell(q_lvl) |-> (run_cnt == (act_div >> 1)));

  // R5: settings hold between boundaries
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> ($stable(act_div) && $stable(byp_act)));

  // R6: a new high phase only starts at a boundary
  a_r6_rise_at_bnd: assert property (@(posedge clk) disable iff (rst)
    $rose(q_lvl) |-> $past(bnd));
endmodule

bind pclk_divider pclk_divider_chk u_chk (
  .clk      (clk_ref),
  .rst      (rst),
  .ctl_word (ctl_word),
  .bnd      (bnd),
  .byp_act  (byp_act),
  .q_lvl    (q_lvl),
  .act_div  (act_div)
);

// File: tb/test_pclk_divider.sv
`timescale 1ns/1ps
module test_pclk_divider;
  logic        clk_ref = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctl_word = '0;
  logic [23:0] pick_ref = 24'd1;
  logic [23:0] pick_tgt = 24'd1;
  logic        pix_clk;
  logic [31:0] pick_word;

  always #2 clk_ref = ~clk_ref;

  pclk_divider i_pclk_divider (
    .clk_ref(clk_ref), .rst(rst), .ctl_word(ctl_word), .pix_clk(pix_clk),
    .pick_ref(pick_ref), .pick_tgt(pick_tgt), .pick_word(pick_word)
  );

  typedef struct { int per; int hi; string req; } exp_t;
  exp_t sbq[$];

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit track = 0;
  bit seen_rise = 0;
  realtime last_rise = 0, last_fall = 0;
  realtime min_hi = 1.0e9, min_lo = 1.0e9;

  function automatic int halves(realtime t);
    return $rtoi(t / 2.0 + 0.5);
  endfunction

  task automatic check_int(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: measures each period ending at a rising edge
  always @(posedge pix_clk) begin
    realtime now;
    exp_t e;
    now = $realtime;
    if (track) begin
      if (seen_rise && (now - last_fall) < min_lo) min_lo = now - last_fall;
      if (seen_rise && sbq.size() > 0) begin
        e = sbq.pop_front();
        check_int(e.req, "period_halves", halves(now - last_rise), e.per);
        check_int(e.req, "high_halves", halves(last_fall - last_rise), e.hi);
      end
      last_rise = now;
      seen_rise = 1;
    end
  end

  always @(negedge pix_clk) begin
    if (track) begin
      if (seen_rise && ($realtime - last_rise) < min_hi) min_hi = $realtime - last_rise;
      last_fall = $realtime;
    end
  end

  function automatic logic [31:0] mk(int lo, int hi, bit byp);
    logic [31:0] w;
    w = '0;
    w[4:0]   = lo[4:0];
    w[15:11] = hi[4:0];
    w[5]     = byp;
    return w;
  endfunction

  function automatic logic [31:0] enc(longint d);
    longint v;
    if (d == 1) return mk(0, 0, 1'b1);
    v = d - 2;
    return mk(int'(v % 32), int'(v / 32), 1'b0);
  endfunction

  function automatic logic [31:0] brute(longint r, longint t);
    longint best, bdiff, f, df;
    if (t == 0) return enc(1025);
    best = 1;
    bdiff = 64'h7fffffffffff;
    for (longint d = 1; d <= 1025; d++) begin
      f = (r + d - 1) / d;
      df = (f > t) ? f - t : t - f;
      if (df < bdiff) begin
        bdiff = df;
        best = d;
      end
    end
    return enc(best);
  endfunction

  // driver: apply a word, let it settle, queue three expected periods
  task automatic run_case(logic [31:0] w, int per_h, int hi_h, string req);
    @(negedge clk_ref);
    ctl_word = w;
    repeat (3) @(posedge pix_clk);
    for (int k = 0; k < 3; k++) sbq.push_back('{per_h, hi_h, req});
    wait (sbq.size() == 0);
  endtask

  task automatic pick_case(longint r, longint t, string req);
    @(negedge clk_ref);
    pick_ref = r[23:0];
    pick_tgt = t[23:0];
    #1;
    check_int(req, "pick_word", pick_word, brute(r, t));
  endtask

  initial begin
    realtime t0;
    rst = 1'b1;
    ctl_word = mk(0, 0, 1'b0);
    repeat (3) @(posedge clk_ref);
    #1 check_int("R1", "pix_clk_high_phase", pix_clk, 0);
    @(negedge clk_ref);
    check_int("R1", "pix_clk_low_phase", pix_clk, 0);
    rst = 1'b0;
    track = 1;

    run_case(mk(0, 0, 0), 4, 2, "R2");       // d=2
    run_case(mk(5, 1, 0), 78, 38, "R2");     // d=39
    run_case(mk(0, 2, 0), 132, 66, "R2");    // high field only, d=66
    run_case(mk(1, 0, 0), 6, 2, "R4");       // d=3 odd
    run_case(mk(7, 3, 1), 2, 1, "R3");       // bypass, fields ignored
    run_case(mk(3, 0, 0), 10, 4, "R4");      // exit bypass, d=5
    run_case(mk(0, 0, 1), 2, 1, "R3");       // bypass again
    run_case(mk(31, 31, 0), 2050, 1024, "R9");
    run_case(mk(18, 0, 0), 40, 20, "R5");    // d=20

    // R5: change mid-period, running period keeps old length
    @(posedge pix_clk);
    t0 = $realtime;
    repeat (3) @(negedge clk_ref);
    ctl_word = mk(2, 0, 0);                  // d=4
    @(posedge pix_clk);
    check_int("R5", "period_in_progress", halves($realtime - t0), 40);
    t0 = $realtime;
    @(posedge pix_clk);
    check_int("R5", "first_new_period", halves($realtime - t0), 8);

    repeat (20) @(posedge clk_ref);
    check_int("R6", "min_high_ok", (halves(min_hi) >= 1) ? 1 : 0, 1);
    check_int("R6", "min_low_ok", (halves(min_lo) >= 1) ? 1 : 0, 1);

    pick_case(1000, 300, "R7");
    pick_case(1000, 7, "R7");
    pick_case(5000, 1234, "R7");
    pick_case(10, 4, "R7");
    pick_case(12, 5, "R7");                  // tie -> smaller divisor
    pick_case(100, 100, "R8");
    pick_case(50, 80, "R8");
    pick_case(24'hFFFFFF, 3, "R8");
    @(negedge clk_ref);
    pick_ref = 24'd1000;
    pick_tgt = 24'd0;
    #1 check_int("R8", "pick_zero_target", pick_word, mk(31, 31, 0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule